// File: doc/BRIEF.md
# AXI-to-AHB Burst Bridge

This block sits between an AXI4 manager and an AHB-Lite bus on the same clock. It takes one write or read burst at a time and replays it as single AHB transfers. Only the first address of a burst arrives on the AXI side. The bridge works out every later beat address from the beat count (length field plus one), the size field and the burst type. For writes it pairs the accepted write address with the write-data beats one at a time. Each AHB beat has a separate address phase and data phase. The bridge holds both phases while the slave stretches them with `hready` low. It answers with one write response or with one read beat per AHB data phase.

The bridge does not hang on inputs that are commonly wrong. A write beat whose byte strobes are all zero is consumed and counted, but it produces no bus transfer. A size wider than the 32-bit path, or a wrapping burst, gets an error response and never reaches the AHB side. When a read and a write are both waiting, the bridge takes them in turn.

Top module: `axi_ahb_bridge`

## Requirements
- R1: While reset is held, and in the first cycle after it, `htrans` is IDLE (2'b00) and `bvalid` and `rvalid` are low.
- R2: A write transfer (`htrans` NONSEQ or SEQ with `hwrite` high) is placed on the AHB side only while a write-data beat is offered (`wvalid` high). While no W beat is present, `htrans` shows only IDLE or BUSY.
- R3: A legal burst produces exactly length+1 beats. Each beat pops one W beat (writes) or returns one R beat (reads), and every beat with a non-zero strobe makes exactly one AHB transfer.
- R4: For a FIXED burst (burst code 2'b00), every transfer uses the start address, with `htrans` NONSEQ (2'b10) and `hburst` SINGLE (3'b000). `htrans` never shows BUSY during such a burst.
- R5: For an INCR burst (burst code 2'b01), beat i uses the start address plus i times 2^size. The first issued beat is NONSEQ, and each beat that directly follows an issued beat is SEQ (2'b11). `hburst` is INCR (3'b001). Between the beats of a multi-beat INCR burst, `htrans` shows BUSY (2'b01).
- R6: While `hready` is low, an offered address phase keeps `haddr`, `htrans`, `hwrite` and `hsize` unchanged, and a pending write data phase keeps `hwdata` unchanged.
- R7: A write beat whose strobe is 4'b0000 is accepted (`wready` high) with `htrans` IDLE in that cycle. It is counted toward the burst, and the next issued beat is NONSEQ.
- R8: A size above 3'b010, or a burst code of 2'b10 or 2'b11, causes no AHB transfer. A write drains length+1 W beats and answers SLVERR (2'b10). A read returns length+1 beats with data 0 and response SLVERR.
- R9: A write burst gets exactly one B response, after the last beat. It is OKAY (2'b00), or SLVERR if `hresp` was high in any completed data phase. `bresp` and `bvalid` hold while `bready` is low.
- R10: Each R beat carries the `hrdata` seen in the data phase where `hready` is high. It carries SLVERR if `hresp` was high there. `rlast` is high only on beat index equal to the read length. The beat holds while `rready` is low.
- R11: When both AW and AR are pending, the bridge grants the one that was not granted last. After reset, the write is granted first.
- R12: Only one burst is active at a time: `awready` and `arready` stay low from a grant until that burst's B response or last R beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| awaddr | input | ADDR_W | Write burst start address |
| awlen | input | LEN_W | Write beats minus one |
| awsize | input | 3 | Write beat size, log2 bytes |
| awburst | input | 2 | Write burst type |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| araddr | input | ADDR_W | Read burst start address |
| arlen | input | LEN_W | Read beats minus one |
| arsize | input | 3 | Read beat size, log2 bytes |
| arburst | input | 2 | Read burst type |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Last read beat |
| haddr | output | ADDR_W | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB write direction |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done / phase stretch |
| hresp | input | 1 | AHB error response |

## Verification
Bursts are driven in several forms: FIXED and INCR, full-word and halfword sizes, and lengths of one to four beats. Comparing the logged AHB addresses and transfer types between FIXED and INCR bursts shows whether the address is held or stepped and whether SEQ chaining happens. Random `hready`, `bready` and `rready` stalls show that both phases and both response channels hold their values. Write-data gaps show that no write is issued before its data arrives. A zero-strobe beat in mid-burst, an oversize field, a wrapping burst and an `hresp` error each lead to a different expected outcome: a skipped transfer with a NONSEQ restart, a drained burst with SLVERR, or a flagged beat. Simultaneous read and write requests show the grant order before and after each kind of grant.

// File: rtl/axi_ahb_bridge.sv
`timescale 1ns/1ps
module axi_ahb_bridge #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [LEN_W-1:0]  awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              wvalid,
  output logic              wready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [LEN_W-1:0]  arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  output logic              rvalid,
  input  logic              rready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [31:0]       hwdata,
  input  logic [31:0]       hrdata,
  input  logic              hready,
  input  logic              hresp
);

  localparam logic [2:0] MAX_SIZE = 3'd2;
  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [1:0] RSP_OK = 2'b00, RSP_ERR = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_WA, S_WD, S_WE, S_B, S_RA, S_RD, S_RR, S_RE
  } st_t;

  st_t              st;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  len, cnt;
  logic [2:0]        size;
  logic              incr, is_wr, err, linked, pref_r, rerr_q;
  logic [31:0]       hwdata_q, rdata_q;

  wire last_beat = (cnt == len);
  wire [ADDR_W-1:0] step = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
  wire [ADDR_W-1:0] addr_nx = incr ? addr + step : addr;

  wire grant_w = awvalid && !(arvalid && pref_r);
  wire grant_r = arvalid && !grant_w;
  wire aw_bad  = (awsize > MAX_SIZE) || awburst[1];
  wire ar_bad  = (arsize > MAX_SIZE) || arburst[1];

  wire skip_w  = (st == S_WA) && wvalid && (wstrb == 4'b0000);
  wire issue_w = (st == S_WA) && wvalid && (wstrb != 4'b0000);

  assign awready = (st == S_IDLE) && grant_w;
  assign arready = (st == S_IDLE) && grant_r;
  assign wready  = skip_w || (issue_w && hready) || (st == S_WE);

  assign bvalid = (st == S_B);
  assign bresp  = err ? RSP_ERR : RSP_OK;
  assign rvalid = (st == S_RR) || (st == S_RE);
  assign rdata  = (st == S_RE) ? 32'h0 : rdata_q;
  assign rresp  = ((st == S_RE) || rerr_q) ? RSP_ERR : RSP_OK;
  assign rlast  = rvalid && last_beat;

  assign haddr  = addr;
  assign hwrite = is_wr;
  assign hsize  = size;
  assign hburst = incr ? 3'b001 : 3'b000;
  assign hwdata = hwdata_q;

  always_comb begin
    unique case (st)
      S_WA:              htrans = issue_w ? (linked ? T_SEQ : T_NSEQ)
                                 : (skip_w ? T_IDLE : (linked ? T_BUSY : T_IDLE));
      S_RA:              htrans = linked ? T_SEQ : T_NSEQ;
      S_WD, S_RD, S_RR:  htrans = linked ? T_BUSY : T_IDLE;
      default:           htrans = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; len <= '0; cnt <= '0; size <= '0;
      incr <= 1'b0; is_wr <= 1'b0; err <= 1'b0; linked <= 1'b0;
      pref_r <= 1'b0; rerr_q <= 1'b0; hwdata_q <= '0; rdata_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          cnt <= '0; err <= 1'b0; linked <= 1'b0;
          if (grant_w) begin
            addr <= awaddr; len <= awlen; size <= awsize;
            incr <= (awburst == 2'b01); is_wr <= 1'b1; pref_r <= 1'b1;
            err <= aw_bad;
            st <= aw_bad ? S_WE : S_WA;
          end else if (grant_r) begin
            addr <= araddr; len <= arlen; size <= arsize;
            incr <= (arburst == 2'b01); is_wr <= 1'b0; pref_r <= 1'b0;
            st <= ar_bad ? S_RE : S_RA;
          end
        end
        S_WA: begin
          if (skip_w) begin
            linked <= 1'b0; cnt <= cnt + 1'b1; addr <= addr_nx;
            if (last_beat) st <= S_B;
          end else if (issue_w && hready) begin
            hwdata_q <= wdata;
            linked <= incr && !last_beat;
            st <= S_WD;
          end
        end
        S_WD: if (hready) begin
          err <= err | hresp; cnt <= cnt + 1'b1; addr <= addr_nx;
          st <= last_beat ? S_B : S_WA;
        end
        S_WE: if (wvalid) begin
          cnt <= cnt + 1'b1;
          if (last_beat) st <= S_B;
        end
        S_B: if (bready) st <= S_IDLE;
        S_RA: if (hready) begin
          linked <= incr && !last_beat;
          st <= S_RD;
        end
        S_RD: if (hready) begin
          rdata_q <= hrdata; rerr_q <= hresp;
          st <= S_RR;
        end
        S_RR: if (rready) begin
          cnt <= cnt + 1'b1; addr <= addr_nx;
          st <= last_beat ? S_IDLE : S_RA;
        end
        S_RE: if (rready) begin
          cnt <= cnt + 1'b1;
          if (last_beat) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axi_ahb_bridge_chk.sv
`timescale 1ns/1ps
module axi_ahb_bridge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hsize,
  input logic [2:0]        hburst,
  input logic              hready,
  input logic              wvalid,
  input logic              wready,
  input logic [3:0]        wstrb,
  input logic              awready,
  input logic              arready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic              rready,
  input logic [31:0]       rdata,
  input logic              rlast
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (htrans == 2'b00 && !bvalid && !rvalid));

  a_r2_write_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hwrite) |-> wvalid);

  a_r4_fixed_single: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hburst == 3'b000) |-> htrans == 2'b10);

  a_r5_seq_is_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> hburst == 3'b001);

  a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite) && $stable(hsize)));

  a_r7_zero_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready && wstrb == 4'b0000) |-> !htrans[1]);

  a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

  a_r10_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rlast)));

  a_r12_one_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid || rvalid) |-> (!awready && !arready));

endmodule

bind axi_ahb_bridge axi_ahb_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/axi_ahb_bridge_tb_top.sv
`timescale 1ns/1ps
module axi_ahb_bridge_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic awvalid, awready, wvalid, wready, bvalid, bready, arvalid, arready;
  logic rvalid, rready, rlast, hwrite, hready, hresp;
  logic [31:0] awaddr, araddr, wdata, rdata, haddr, hwdata, hrdata;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize, hsize, hburst;
  logic [1:0] awburst, arburst, bresp, rresp, htrans;
  logic [3:0] wstrb;

  axi_ahb_bridge dut_i (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic [3:0]  strb;
    logic        zb_en;
    logic [7:0]  zb;
    logic        er_en;
    logic [7:0]  er;
    logic        stall;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h100, 8'd3, 3'd2, 2'b01, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0},
    '{1'b1, 32'h200, 8'd2, 3'd2, 2'b00, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
    '{1'b0, 32'h300, 8'd3, 3'd2, 2'b01, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
    '{1'b0, 32'h400, 8'd1, 3'd2, 2'b00, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0},
    '{1'b1, 32'h500, 8'd2, 3'd1, 2'b01, 4'h3, 1'b0, 8'd0, 1'b1, 8'd1, 1'b1},
    '{1'b1, 32'h700, 8'd3, 3'd2, 2'b01, 4'hF, 1'b1, 8'd1, 1'b0, 8'd0, 1'b0},
    '{1'b1, 32'hA00, 8'd1, 3'd3, 2'b01, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0},
    '{1'b0, 32'hB00, 8'd2, 3'd2, 2'b10, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
    '{1'b0, 32'h603, 8'd0, 3'd0, 2'b01, 4'hF, 1'b0, 8'd0, 1'b1, 8'd0, 1'b0},
    '{1'b1, 32'hC00, 8'd0, 3'd2, 2'b01, 4'hF, 1'b1, 8'd0, 1'b0, 8'd0, 1'b0}
  };

  int n_chk = 0, n_fail = 0;
  int log_n, r_n, b_cnt = 0, g_n, busy_cyc;
  int r2_viol = 0, r6_viol = 0, r12_viol = 0;
  logic [31:0] log_addr [0:63], log_wd [0:63], r_data [0:63];
  logic [1:0]  log_tr [0:63], r_resp [0:63];
  logic [2:0]  log_bu [0:63], log_sz [0:63];
  logic        log_wr [0:63], r_last [0:63], grant_w [0:7];
  logic [1:0]  b_last;
  logic        dp_pending = 1'b0, w_gap = 1'b0, busy_f = 1'b0;
  logic [31:0] dp_addr = '0, err_addr = '0;
  logic        stall_en = 1'b0, err_en = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic        p_stall = 1'b0, p_dstall = 1'b0;
  logic [31:0] p_haddr = '0, p_hwdata = '0;
  logic [1:0]  p_htrans = '0;

  function automatic logic [31:0] beat_addr(vec_t v, int i);
    return (v.burst == 2'b01) ? v.addr + (32'(i) << v.size) : v.addr;
  endfunction
  function automatic logic [31:0] wd_of(int k, int i);
    return 32'hC0DE_0000 ^ (32'(k) << 8) ^ 32'(i);
  endfunction
  function automatic logic [31:0] rd_of(logic [31:0] a);
    return a ^ 32'h5A5A_A5A5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // AHB slave and ready drivers
  always @(negedge clk) begin
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    hready = !stall_en || lfsr[0] || lfsr[2];
    bready = !stall_en || lfsr[1];
    rready = !stall_en || lfsr[3];
    hrdata = rd_of(dp_addr);
    hresp  = err_en && dp_pending && (dp_addr == err_addr);
  end

  // Monitor, one nanosecond before each rising edge
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (p_stall && (haddr !== p_haddr || htrans !== p_htrans)) r6_viol++;
      if (p_dstall && hwdata !== p_hwdata) r6_viol++;
      p_stall  = htrans[1] && !hready;
      p_dstall = dp_pending && !hready && hwrite;
      p_haddr = haddr; p_htrans = htrans; p_hwdata = hwdata;
      if (w_gap && htrans[1] && hwrite) r2_viol++;
      if (htrans == 2'b01) busy_cyc++;
      if (dp_pending && hready) begin
        log_wd[log_n-1] = hwdata;
        dp_pending = 1'b0;
      end
      if (htrans[1] && hready) begin
        log_addr[log_n] = haddr; log_tr[log_n] = htrans; log_bu[log_n] = hburst;
        log_sz[log_n] = hsize; log_wr[log_n] = hwrite;
        log_n++;
        dp_pending = 1'b1; dp_addr = haddr;
      end
      if (busy_f && (awready || arready)) r12_viol++;
      if (awvalid && awready) begin busy_f = 1'b1; grant_w[g_n] = 1'b1; g_n++; end
      if (arvalid && arready) begin busy_f = 1'b1; grant_w[g_n] = 1'b0; g_n++; end
      if (bvalid && bready) begin b_cnt++; b_last = bresp; busy_f = 1'b0; end
      if (rvalid && rready) begin
        r_data[r_n] = rdata; r_resp[r_n] = rresp; r_last[r_n] = rlast; r_n++;
        if (rlast) busy_f = 1'b0;
      end
    end
  end

  task automatic drive_aw(input vec_t v);
    bit ok = 0;
    @(negedge clk);
    awvalid = 1; awaddr = v.addr; awlen = v.len; awsize = v.size; awburst = v.burst;
    do begin #3; ok = awready; @(negedge clk); end while (!ok);
    awvalid = 0;
  endtask

  task automatic drive_ar(input vec_t v);
    bit ok = 0;
    @(negedge clk);
    arvalid = 1; araddr = v.addr; arlen = v.len; arsize = v.size; arburst = v.burst;
    do begin #3; ok = arready; @(negedge clk); end while (!ok);
    arvalid = 0;
  endtask

  task automatic drive_w(input vec_t v, input int k, input int gap);
    @(negedge clk);
    for (int i = 0; i <= int'(v.len); i++) begin
      bit ok = 0;
      if (gap > 0) begin
        wvalid = 0; w_gap = 1;
        repeat (gap) @(negedge clk);
        w_gap = 0;
      end
      wvalid = 1; wdata = wd_of(k, i);
      wstrb = (v.zb_en && i == int'(v.zb)) ? 4'b0000 : v.strb;
      do begin #3; ok = wready; @(negedge clk); end while (!ok);
    end
    wvalid = 0;
  endtask

  task automatic wait_done(input vec_t v, input int b0);
    if (v.wr) while (b_cnt == b0) @(negedge clk);
    else while (r_n < int'(v.len) + 1) @(negedge clk);
  endtask

  task automatic check_vec(input vec_t v, input int k, input int b0);
    bit bad = (v.size > 3'd2) || v.burst[1];
    bit prev = 0, any_err = 0;
    int e = 0;
    for (int i = 0; i <= int'(v.len); i++) begin
      if (bad) continue;
      if (v.wr && v.zb_en && i == int'(v.zb)) begin prev = 0; continue; end
      if (v.burst == 2'b01) begin
        chk("R5 incr address", log_addr[e], beat_addr(v, i));
        chk("R5 htrans", {30'd0, log_tr[e]}, (i > 0 && prev) ? 32'd3 : 32'd2);
        chk("R5 hburst", {29'd0, log_bu[e]}, 32'd1);
      end else begin
        chk("R4 fixed address", log_addr[e], v.addr);
        chk("R4 htrans", {30'd0, log_tr[e]}, 32'd2);
        chk("R4 hburst", {29'd0, log_bu[e]}, 32'd0);
      end
      chk("R3 hwrite", {31'd0, log_wr[e]}, {31'd0, v.wr});
      chk("R3 hsize", {29'd0, log_sz[e]}, {29'd0, v.size});
      if (v.wr) chk("R6 hwdata", log_wd[e], wd_of(k, i));
      if (v.er_en && i == int'(v.er)) any_err = 1;
      prev = 1; e++;
    end
    chk(bad ? "R8 no transfers" : (v.zb_en ? "R7 transfer count" : "R3 transfer count"),
        32'(log_n), 32'(e));
    if (!bad && v.burst == 2'b00) chk("R4 no busy", 32'(busy_cyc), 32'd0);
    if (!bad && v.burst == 2'b01 && e > 1) chk("R5 busy seen", {31'd0, busy_cyc > 0}, 32'd1);
    if (v.wr) begin
      chk("R9 one response", 32'(b_cnt - b0), 32'd1);
      chk(bad ? "R8 bresp" : "R9 bresp", {30'd0, b_last}, (bad || any_err) ? 32'd2 : 32'd0);
    end else begin
      chk(bad ? "R8 beat count" : "R3 beat count", 32'(r_n), 32'(int'(v.len) + 1));
      for (int i = 0; i <= int'(v.len); i++) begin
        chk(bad ? "R8 rdata" : "R10 rdata", r_data[i], bad ? 32'd0 : rd_of(beat_addr(v, i)));
        chk(bad ? "R8 rresp" : "R10 rresp", {30'd0, r_resp[i]},
            (bad || (v.er_en && i == int'(v.er))) ? 32'd2 : 32'd0);
        chk("R10 rlast", {31'd0, r_last[i]}, {31'd0, i == int'(v.len)});
      end
    end
  endtask

  task automatic run_vec(input int k);
    vec_t v = VECS[k];
    int b0 = b_cnt;
    log_n = 0; r_n = 0; busy_cyc = 0;
    stall_en = v.stall; err_en = v.er_en; err_addr = beat_addr(v, int'(v.er));
    if (v.wr) fork drive_aw(v); drive_w(v, k, (k == 5) ? 3 : 0); join
    else drive_ar(v);
    wait_done(v, b0);
    repeat (3) @(negedge clk);
    stall_en = 0; err_en = 0;
    check_vec(v, k, b0);
  endtask

  task automatic run_pair(input bit w_first);
    vec_t pw = '{1'b1, 32'h800, 8'd0, 3'd2, 2'b01, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0};
    vec_t pr = '{1'b0, 32'h900, 8'd0, 3'd2, 2'b01, 4'hF, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0};
    int b0 = b_cnt;
    g_n = 0; log_n = 0; r_n = 0;
    fork
      begin fork drive_aw(pw); drive_w(pw, 20, 0); join end
      drive_ar(pr);
    join
    wait_done(pw, b0);
    wait_done(pr, 0);
    repeat (2) @(negedge clk);
    chk("R11 first grant", {31'd0, grant_w[0]}, {31'd0, w_first});
    chk("R11 second grant", {31'd0, grant_w[1]}, {31'd0, !w_first});
    chk("R10 pair rdata", r_data[0], rd_of(32'h900));
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; awvalid = 0; wvalid = 0; arvalid = 0;
    awaddr = '0; awlen = '0; awsize = '0; awburst = '0;
    araddr = '0; arlen = '0; arsize = '0; arburst = '0;
    wdata = '0; wstrb = '0;
    repeat (3) @(negedge clk);
    #3;
    chk("R1 htrans in reset", {30'd0, htrans}, 32'd0);
    chk("R1 bvalid in reset", {31'd0, bvalid}, 32'd0);
    chk("R1 rvalid in reset", {31'd0, rvalid}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    #3;
    chk("R1 htrans after reset", {30'd0, htrans}, 32'd0);
    run_pair(1'b1);
    for (int k = 0; k < NV; k++) run_vec(k);
    run_pair(1'b0);
    chk("R2 no write without data", 32'(r2_viol), 32'd0);
    chk("R6 hold under stall", 32'(r6_viol), 32'd0);
    chk("R12 single transaction", 32'(r12_viol), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule